// File: doc/BRIEF.md
# Trace Capture Stop-Trigger Controller

This block governs one on-chip instruction trace buffer. It decides when capture runs, notices the first request to stop, and keeps capture going for a programmed tail before it ends. Capture opens on a rising edge of a level enable input. Four sources can close it: a software stop request, a masked program-counter comparator, a processor trigger input and a cross-trigger input. The last three each have their own enable.

After the stop trigger fires, a delay counter is loaded. It counts down either per trace word written or per retired instruction. Capture ends when it reaches zero. While capture runs, the block produces the word write strobe and the word address for trace memory. The address walks a window from a start address to an end address. A wrap counter tracks how many times it returns to the start, and a sticky flag records when that counter overflows. Two trigger outputs can each be set to assert from the stop trigger onward, or from completion onward.

Top module: `trace_stop_ctrl`

## Requirements
- R1: A 0-to-1 change of `trc_en` seen on a clock edge sets `active` on that edge and loads `mem_addr` with `start_addr`. It also clears `wrap_cnt` to 0. Holding `trc_en` high does not restart capture.
- R2: While `active` is 1 and `triggered` is 0, a high `stop_req` sets `triggered` on the next edge. It records no cause flag.
- R3: The PC comparator ignores the lowest `pc_ignore` bits of `cur_pc` and `trig_pc`. A PC hit counts only on a cycle with `instr_valid` high.
- R4: With `pc_sense`=0, a hit is equality of the unmasked upper bits. With `pc_sense`=1, a hit is inequality of those bits.
- R5: A PC hit, `proc_trig_in` or `cross_trig_in` stops capture only while its enable (`pcm_en`, `pti_en`, `cti_en`) is 1. Otherwise it has no effect on any output.
- R6: On the trigger edge the delay counter loads `delay_cnt`. After that it decrements on each tick: a cycle with `word_wr` when `cnt_by_instr`=0, or with `instr_valid` when `cnt_by_instr`=1. On the first edge where `active` and `triggered` are both 1 and the counter is 0, `active` clears.
- R7: Only the source that fires the trigger sets its cause flag. Simultaneous sources are ranked PC, then processor trigger, then cross trigger. Later hits leave the flags unchanged. `triggered` and all cause flags clear on the edge where `trc_en` goes from 1 to 0.
- R8: `mem_we` equals `active` AND `word_wr`. Each write advances `mem_addr` by one word. A write at `end_addr` returns `mem_addr` to `start_addr` and increments the 10-bit `wrap_cnt`.
- R9: When `wrap_cnt` rolls over from 1023 to 0, `wrap_sat` is set and stays set. It clears only on a 1-to-0 change of `trc_en`.
- R10: `proc_trig_out` is (`pto_on_trig` AND `triggered`) OR (`pto_on_done` AND `triggered` AND NOT `active`). `cross_trig_out` follows the same rule using `cto_on_trig` and `cto_on_done`.
- R11: `size_log2` reads the constant ADDR_W+2, giving the usable buffer as 2^size_log2 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trc_en | input | 1 | Capture enable level |
| stop_req | input | 1 | Software stop request |
| pcm_en | input | 1 | PC-match source enable |
| pti_en | input | 1 | Processor-trigger source enable |
| cti_en | input | 1 | Cross-trigger source enable |
| pc_sense | input | 1 | 0: hit when inside the masked range, 1: hit when outside it |
| pc_ignore | input | 5 | Count of low PC bits ignored |
| trig_pc | input | 32 | Trigger PC value |
| cur_pc | input | 32 | PC of the retiring instruction |
| instr_valid | input | 1 | An instruction retires this cycle |
| word_wr | input | 1 | The encoder offers a trace word this cycle |
| cnt_by_instr | input | 1 | Delay units: 0 words, 1 instructions |
| delay_cnt | input | 16 | Post-trigger delay |
| start_addr | input | 8 | First word of the trace window |
| end_addr | input | 8 | Last word of the trace window |
| proc_trig_in | input | 1 | Processor trigger input |
| cross_trig_in | input | 1 | Cross-trigger input |
| pto_on_trig | input | 1 | Processor trigger out from trigger onward |
| pto_on_done | input | 1 | Processor trigger out from completion onward |
| cto_on_trig | input | 1 | Cross-trigger out from trigger onward |
| cto_on_done | input | 1 | Cross-trigger out from completion onward |
| active | output | 1 | Capture running |
| triggered | output | 1 | Stop trigger has fired |
| cause_pc | output | 1 | Trigger came from the PC match |
| cause_pti | output | 1 | Trigger came from the processor trigger input |
| cause_cti | output | 1 | Trigger came from the cross-trigger input |
| mem_we | output | 1 | Trace memory write strobe |
| mem_addr | output | 8 | Trace memory word address |
| wrap_cnt | output | 10 | Count of address wraps |
| wrap_sat | output | 1 | Wrap counter overflowed (sticky) |
| size_log2 | output | 5 | log2 of the buffer size in bytes |
| proc_trig_out | output | 1 | Processor trigger output |
| cross_trig_out | output | 1 | Cross-trigger output |

## Verification
The first run stops through the software request with a word-counted delay. Its write strobes are irregular, so the delay is only consumed on write cycles. The second run fires the PC, processor and cross sources on the same cycle with instruction-counted delay. This separates the priority order and the first-cause-only rule from the choice of units. The third run shows three things: a disabled source is ignored, a sense inversion hits on a PC outside the range, and ignore widths decide whether near-miss PCs hit. A long run over a two-word window drives the wrap counter through rollover to separate its wrap count from the sticky saturation flag.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef struct packed {
    logic pc;
    logic pti;
    logic cti;
  } cause_t;
endpackage

// File: rtl/tsc_pc_match.sv
module tsc_pc_match #(
  parameter int PC_W  = 32,
  parameter int IGN_W = 5
) (
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [PC_W-1:0]  trig_pc,
  input  logic [IGN_W-1:0] ignore,
  input  logic             sense,
  input  logic             valid,
  input  logic             enable,
  output logic             hit
);
  logic [PC_W-1:0] keep_mask;
  logic            in_range;

  always_comb begin
    keep_mask = {PC_W{1'b1}} << ignore;
    in_range  = ((cur_pc ^ trig_pc) & keep_mask) == '0;
    hit       = enable & valid & (in_range ^ sense);
  end
endmodule

// File: rtl/tsc_delay.sv
module tsc_delay #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             running,
  input  logic             tick,
  output logic             expired
);
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    expired = (cnt_q == '0);
    cnt_en  = load | (running & tick & ~expired);
    cnt_d   = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_cnt_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !load && tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(running && tick)) |=> $stable(cnt_q));
endmodule

// File: rtl/tsc_wptr.sv
module tsc_wptr #(
  parameter int ADDR_W = 8,
  parameter int WRAP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              clr_sat,
  input  logic              we,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  output logic [ADDR_W-1:0] addr,
  output logic [WRAP_W-1:0] wraps,
  output logic              sat
);
  logic [ADDR_W-1:0] addr_d;
  logic [WRAP_W-1:0] wraps_d;
  logic              sat_d, at_end, ptr_en;

  always_comb begin
    at_end  = (addr == end_addr);
    ptr_en  = restart | we;
    addr_d  = addr + 1'b1;
    wraps_d = wraps;
    sat_d   = sat;
    if (restart) begin
      addr_d  = start_addr;
      wraps_d = '0;
    end else if (we && at_end) begin
      addr_d  = start_addr;
      wraps_d = wraps + 1'b1;
      if (&wraps) sat_d = 1'b1;
    end
    if (clr_sat) sat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      wraps <= '0;
    end else if (ptr_en) begin
      addr  <= addr_d;
      wraps <= wraps_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sat <= 1'b0;
    else        sat <= sat_d;
  end

  assert_wrap_to_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !restart && at_end) |=> addr == $past(start_addr));
  assert_sat_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && !clr_sat) |=> sat);
  assert_sat_on_roll_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !restart && at_end && (&wraps) && !clr_sat) |=> sat);
endmodule

// File: rtl/trace_stop_ctrl.sv
module trace_stop_ctrl #(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 8,
  parameter int WRAP_W = 10,
  parameter int DLY_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trc_en,
  input  logic              stop_req,
  input  logic              pcm_en,
  input  logic              pti_en,
  input  logic              cti_en,
  input  logic              pc_sense,
  input  logic [4:0]        pc_ignore,
  input  logic [PC_W-1:0]   trig_pc,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic              instr_valid,
  input  logic              word_wr,
  input  logic              cnt_by_instr,
  input  logic [DLY_W-1:0]  delay_cnt,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic              proc_trig_in,
  input  logic              cross_trig_in,
  input  logic              pto_on_trig,
  input  logic              pto_on_done,
  input  logic              cto_on_trig,
  input  logic              cto_on_done,
  output logic              active,
  output logic              triggered,
  output logic              cause_pc,
  output logic              cause_pti,
  output logic              cause_cti,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WRAP_W-1:0] wrap_cnt,
  output logic              wrap_sat,
  output logic [4:0]        size_log2,
  output logic              proc_trig_out,
  output logic              cross_trig_out
);
  import tsc_pkg::*;

  localparam int SIZE_LOG2 = ADDR_W + 2;

  logic   en_q, en_rise, en_fall;
  logic   pc_hit, pti_hit, cti_hit, fire, done, tick, expired;
  logic   active_d, trig_d;
  cause_t cause_q, cause_d;

  tsc_pc_match #(.PC_W(PC_W), .IGN_W(5)) u_pcm (
    .cur_pc(cur_pc), .trig_pc(trig_pc), .ignore(pc_ignore),
    .sense(pc_sense), .valid(instr_valid), .enable(pcm_en), .hit(pc_hit)
  );

  tsc_delay #(.DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(fire), .load_val(delay_cnt),
    .running(active & triggered), .tick(tick), .expired(expired)
  );

  tsc_wptr #(.ADDR_W(ADDR_W), .WRAP_W(WRAP_W)) u_wptr (
    .clk(clk), .rst_n(rst_n), .restart(en_rise), .clr_sat(en_fall),
    .we(mem_we), .start_addr(start_addr), .end_addr(end_addr),
    .addr(mem_addr), .wraps(wrap_cnt), .sat(wrap_sat)
  );

  always_comb begin
    en_rise  = trc_en & ~en_q;
    en_fall  = ~trc_en & en_q;
    pti_hit  = pti_en & proc_trig_in;
    cti_hit  = cti_en & cross_trig_in;
    fire     = active & ~triggered & (stop_req | pc_hit | pti_hit | cti_hit);
    done     = active & triggered & expired;
    tick     = cnt_by_instr ? instr_valid : word_wr;
    mem_we   = active & word_wr;

    active_d = active;
    if (en_rise)              active_d = 1'b1;
    else if (en_fall || done) active_d = 1'b0;

    trig_d  = triggered;
    cause_d = cause_q;
    if (en_fall || en_rise) begin
      trig_d  = 1'b0;
      cause_d = '0;
    end else if (fire) begin
      trig_d      = 1'b1;
      cause_d.pc  = pc_hit;
      cause_d.pti = ~pc_hit & pti_hit;
      cause_d.cti = ~pc_hit & ~pti_hit & cti_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      active    <= 1'b0;
      triggered <= 1'b0;
      cause_q   <= '0;
    end else begin
      en_q      <= trc_en;
      active    <= active_d;
      triggered <= trig_d;
      cause_q   <= cause_d;
    end
  end

  assign cause_pc       = cause_q.pc;
  assign cause_pti      = cause_q.pti;
  assign cause_cti      = cause_q.cti;
  assign size_log2      = 5'(SIZE_LOG2);
  assign proc_trig_out  = triggered & (pto_on_trig | (pto_on_done & ~active));
  assign cross_trig_out = triggered & (cto_on_trig | (cto_on_done & ~active));

  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (trc_en && !en_q) |=> (active && mem_addr == $past(start_addr)));
  assert_cause_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cause_pc, cause_pti, cause_cti}));
  assert_cause_needs_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_pc || cause_pti || cause_cti) |-> triggered);
  assert_cause_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered && trc_en && en_q) |=> $stable({cause_pc, cause_pti, cause_cti}));
  assert_stop_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !triggered && stop_req && trc_en && en_q) |=> triggered);
  assert_fall_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trc_en && en_q) |=> (!triggered && !active));
endmodule

// File: tb/trace_stop_ctrl_bench.sv
module trace_stop_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic trc_en = 0, stop_req = 0, pcm_en = 0, pti_en = 0, cti_en = 0, pc_sense = 0;
  logic [4:0] pc_ignore = 0;
  logic [31:0] trig_pc = 0, cur_pc = 0;
  logic instr_valid = 0, word_wr = 0, cnt_by_instr = 0;
  logic [15:0] delay_cnt = 0;
  logic [7:0] start_addr = 0, end_addr = 0;
  logic proc_trig_in = 0, cross_trig_in = 0;
  logic pto_on_trig = 0, pto_on_done = 0, cto_on_trig = 0, cto_on_done = 0;
  logic active, triggered, cause_pc, cause_pti, cause_cti, mem_we, wrap_sat;
  logic proc_trig_out, cross_trig_out;
  logic [7:0] mem_addr;
  logic [9:0] wrap_cnt;
  logic [4:0] size_log2;

  int checks = 0, fails = 0;

  trace_stop_ctrl u_trace_stop_ctrl (.*);

  always #5ns clk = ~clk;

  // behavioural reference state
  bit m_enq, m_act, m_trig, m_cpc, m_cpti, m_ccti, m_sat;
  int m_addr, m_wrap, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_enq = 0; m_act = 0; m_trig = 0; m_cpc = 0; m_cpti = 0; m_ccti = 0;
      m_sat = 0; m_addr = 0; m_wrap = 0; m_cnt = 0;
    end else begin
      bit rise, fall, pch, ptih, ctih, fire, done, tk, we;
      rise = trc_en && !m_enq;
      fall = !trc_en && m_enq;
      pch  = pcm_en && instr_valid && (((cur_pc >> pc_ignore) == (trig_pc >> pc_ignore)) != pc_sense);
      ptih = pti_en && proc_trig_in;
      ctih = cti_en && cross_trig_in;
      fire = m_act && !m_trig && (stop_req || pch || ptih || ctih);
      done = m_act && m_trig && m_cnt == 0;
      tk   = cnt_by_instr ? instr_valid : word_wr;
      we   = m_act && word_wr;
      if (rise) begin m_addr = start_addr; m_wrap = 0; end
      else if (we) begin
        if (m_addr == end_addr) begin
          m_addr = start_addr;
          if (m_wrap == 1023) m_sat = 1;
          m_wrap = (m_wrap + 1) % 1024;
        end else m_addr = (m_addr + 1) % 256;
      end
      if (fall) m_sat = 0;
      if (fire) m_cnt = delay_cnt;
      else if (m_act && m_trig && m_cnt != 0 && tk) m_cnt = m_cnt - 1;
      if (rise || fall) begin m_trig = 0; m_cpc = 0; m_cpti = 0; m_ccti = 0; end
      else if (fire) begin
        m_trig = 1;
        if (pch) m_cpc = 1; else if (ptih) m_cpti = 1; else if (ctih) m_ccti = 1;
      end
      if (rise) m_act = 1; else if (fall || done) m_act = 0;
      m_enq = trc_en;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // compare every cycle, after both model and design have settled
  always @(posedge clk) begin
    #2;
    chk("R1 active", active, m_act);
    chk("R2 triggered", triggered, m_trig);
    chk("R7 cause_pc", cause_pc, m_cpc);
    chk("R7 cause_pti", cause_pti, m_cpti);
    chk("R7 cause_cti", cause_cti, m_ccti);
    chk("R8 mem_we", mem_we, m_act && word_wr);
    chk("R8 mem_addr", mem_addr, m_addr);
    chk("R8 wrap_cnt", wrap_cnt, m_wrap);
    chk("R9 wrap_sat", wrap_sat, m_sat);
    chk("R10 proc_trig_out", proc_trig_out, m_trig && (pto_on_trig || (pto_on_done && !m_act)));
    chk("R10 cross_trig_out", cross_trig_out, m_trig && (cto_on_trig || (cto_on_done && !m_act)));
    chk("R11 size_log2", size_log2, 10);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000ns;
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cyc(3);
    chk("R1 reset active", active, 0);
    rst_n = 1;
    // Run A: software stop, word-counted delay of 3 (R2, R6, R8, R10)
    start_addr = 8'd4; end_addr = 8'd7; delay_cnt = 16'd3;
    pto_on_trig = 1; cto_on_done = 1;
    cyc(1); trc_en = 1;
    cyc(1); chk("R1 start addr", mem_addr, 4);
    for (int i = 0; i < 12; i++) begin word_wr = (i % 3 != 1); cyc(1); end
    stop_req = 1; cyc(1); stop_req = 0;
    for (int i = 0; i < 10; i++) begin word_wr = (i % 2 == 0); cyc(1); end
    chk("R6 ended after word delay", active, 0);
    chk("R2 no cause for stop", cause_pc | cause_pti | cause_cti, 0);
    word_wr = 0; cyc(2);
    trc_en = 0; cyc(2);
    chk("R7 fall clears trig", triggered, 0);
    // Run B: simultaneous sources, instruction delay 2 (R3, R6, R7)
    pto_on_trig = 0; pto_on_done = 1; cto_on_done = 0; cto_on_trig = 1;
    cnt_by_instr = 1; delay_cnt = 16'd2; trig_pc = 32'h0000_1230;
    pc_ignore = 5'd4; pcm_en = 1; pti_en = 1; cti_en = 1;
    trc_en = 1; cyc(2);
    instr_valid = 1; cur_pc = 32'h0000_1240; word_wr = 1; cyc(3);
    chk("R3 near miss no hit", triggered, 0);
    cur_pc = 32'h0000_123C; proc_trig_in = 1; cross_trig_in = 1; cyc(1);
    proc_trig_in = 0; cross_trig_in = 0; cur_pc = 32'h10; cyc(1);
    chk("R7 pc wins priority", cause_pc, 1);
    instr_valid = 0; cyc(3);
    chk("R6 waits for instructions", active, 1);
    proc_trig_in = 1; instr_valid = 1; cyc(1); proc_trig_in = 0; cyc(4);
    chk("R7 cause unchanged", cause_pti, 0);
    chk("R6 ended after instr delay", active, 0);
    trc_en = 0; instr_valid = 0; word_wr = 0; cyc(2);
    // Run C: disabled sources, sense inversion (R4, R5)
    trc_en = 1; cnt_by_instr = 0; delay_cnt = 16'd1; pti_en = 0; cti_en = 0;
    pc_sense = 1; pc_ignore = 5'd8; cur_pc = 32'h0000_12FF; instr_valid = 1;
    proc_trig_in = 1; cross_trig_in = 1; cyc(4);
    chk("R5 disabled sources ignored", triggered, 0);
    pcm_en = 0; cur_pc = 32'h0000_5000; cyc(3);
    chk("R5 pc disabled ignored", triggered, 0);
    pcm_en = 1; cyc(2);
    chk("R4 outside-range hit", cause_pc, 1);
    proc_trig_in = 0; cross_trig_in = 0; instr_valid = 0; word_wr = 1; cyc(4);
    trc_en = 0; word_wr = 0; pcm_en = 0; cyc(2);
    // Run D: wrap saturation over a two-word window (R8, R9)
    start_addr = 0; end_addr = 1; trc_en = 1; cyc(1);
    word_wr = 1; cyc(2100);
    chk("R9 saturated", wrap_sat, 1);
    word_wr = 0; cyc(2);
    trc_en = 0; cyc(2);
    chk("R9 cleared by fall", wrap_sat, 0);
    cyc(2);
    summary();
  end
endmodule